// File: doc/BRIEF.md
# Power Amplifier Ramp Sequencer

This block generates the digital control code that drives a transmit power amplifier through one burst. A small shape table of 64 ten-bit words is written once through a plain register-write port. Each word carries two independent five-bit shape samples: the low field shapes the rising edge of the burst and the high field shapes the falling edge. The two samples share an address, but each ramp reads only its own field.

When the burst-enable input rises, the block waits a programmed number of quarter-bit strobes. It then walks the table upward while feeding the low field to the output stage. It holds the final sample while the burst lasts. When burst-enable falls, it walks the table downward while feeding the high field. The table advances on a 4 MHz tick strobe, or on every second tick when the slow-rate input is set.

The selected shape sample is combined with an 8-bit level and an 8-bit offset in one of two arithmetic modes. The result is registered and presented as a 16-bit code. The output is forced to zero outside a ramp, in power-down, and whenever the level is zero.

Top module: `pa_ramp_seq`

## Requirements
- R1: A cycle with `tbl_we` high stores `tbl_wdata` at `tbl_waddr`. Bits [4:0] of a word are the rising-ramp shape and bits [9:5] are the falling-ramp shape.
- R2: After reset, and whenever no ramp or hold is in progress, `ctrl_out` is 0 regardless of mode, level and offset.
- R3: A rising edge of `burst_en` starts a wait of `dly_qbits` pulses of `qbit_stb`. With `dly_qbits` = 0, the rising ramp starts on the next cycle. During the wait the output is 0, and a fall of `burst_en` during the wait returns the block to idle.
- R4: The rising ramp starts at address 0 and advances by one address per step, up to address 62, reading bits [4:0].
- R5: With `slow_rate` = 0, every `tick_4m` pulse is a step. With `slow_rate` = 1, only every second `tick_4m` pulse is a step, counted from the entry into a ramp.
- R6: A step taken at address 62 of the rising ramp enters the hold state. Hold keeps address 62 for as long as `burst_en` stays high.
- R7: Once `burst_en` is low during the rising ramp or hold, the falling ramp starts at address 63, even if the rising ramp is unfinished. Each step lowers the address by one. A step taken at address 1 returns the block to idle. The falling ramp reads bits [9:5].
- R8: With `offs_mode` = 0, the output is shape × (level + offset).
- R9: With `offs_mode` = 1, the output is shape × level + offset.
- R10: While `pwr_down` is 1, or while `level` is 0, the output is 0.
- R11: A rising edge of `burst_en` during the falling ramp is ignored. A new burst needs a fresh rising edge seen in idle.
- R12: `ctrl_out` is registered. It reflects the state and inputs of the previous clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_4m | input | 1 | One-cycle 4 MHz step strobe |
| qbit_stb | input | 1 | One-cycle quarter-bit strobe for the start delay |
| burst_en | input | 1 | Burst enable; rising edge starts, falling edge ends |
| pwr_down | input | 1 | Forces output to zero |
| slow_rate | input | 1 | 1 halves the step rate |
| offs_mode | input | 1 | Selects offset arithmetic |
| level | input | 8 | Power level |
| offset | input | 8 | Output offset |
| dly_qbits | input | 4 | Start delay in quarter bits |
| tbl_we | input | 1 | Table write enable |
| tbl_waddr | input | 6 | Table write address |
| tbl_wdata | input | 10 | Table write data |
| ctrl_out | output | 16 | Registered control code |

## Verification
The bench checks the delay count by issuing step ticks while one quarter-bit strobe is still owed. A design that counts one strobe short would already be ramping and show a non-zero code. The bench drops burst-enable partway through the rising ramp. A design that finishes the rising ramp first, or that resumes the falling ramp below address 63, would show the wrong falling-field sample. At the slow rate, the bench counts ticks from ramp entry, so a design that steps on every tick would land two addresses further. The bench raises burst-enable again during the falling ramp. A design that reacts to level rather than to an edge would restart the burst after the ramp ends instead of staying at zero. Both arithmetic modes are driven at full-scale level and offset, which catches a truncated product.

// File: rtl/pa_ramp_pkg.sv
package pa_ramp_pkg;
   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_DELAY = 3'd1,
      ST_UP    = 3'd2,
      ST_HOLD  = 3'd3,
      ST_DOWN  = 3'd4
   } ramp_state_e;
endpackage

// File: rtl/pa_ramp_table.sv
module pa_ramp_table #(
   parameter int ADDR_W = 6,
   parameter int WORD_W = 10
) (
   input  logic              clk,
   input  logic              we,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [WORD_W-1:0] wdata,
   input  logic [ADDR_W-1:0] raddr,
   output logic [WORD_W-1:0] rdata
);
   localparam int DEPTH = 1 << ADDR_W;

   logic [WORD_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
   end

   assign rdata = mem[raddr];
endmodule

// File: rtl/pa_ramp_fsm.sv
module pa_ramp_fsm
   import pa_ramp_pkg::*;
#(
   parameter int ADDR_W = 6,
   parameter int DLY_W  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_4m,
   input  logic              qbit_stb,
   input  logic              burst_en,
   input  logic              slow_rate,
   input  logic [DLY_W-1:0]  dly_qbits,
   output ramp_state_e       st,
   output logic [ADDR_W-1:0] addr,
   output logic              step_en,
   output logic              burst_rise
);
   localparam logic [ADDR_W-1:0] ADDR_LAST = {ADDR_W{1'b1}};
   localparam logic [ADDR_W-1:0] ADDR_PEAK = ADDR_LAST - 1'b1;
   localparam logic [ADDR_W-1:0] ADDR_LOW  = {{(ADDR_W-1){1'b0}}, 1'b1};

   logic             burst_q;
   logic             phase;
   logic             ramping;
   logic [DLY_W-1:0] dly_cnt;

   assign ramping    = (st == ST_UP) || (st == ST_DOWN);
   assign burst_rise = burst_en & ~burst_q;
   assign step_en    = ramping & tick_4m & (~slow_rate | phase);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= ST_IDLE;
         addr    <= '0;
         dly_cnt <= '0;
         phase   <= 1'b0;
         burst_q <= 1'b0;
      end else begin
         burst_q <= burst_en;
         if (!ramping)     phase <= 1'b0;
         else if (tick_4m) phase <= slow_rate ? ~phase : 1'b0;
         unique case (st)
            ST_IDLE: begin
               if (burst_rise) begin
                  addr <= '0;
                  if (dly_qbits == '0) st <= ST_UP;
                  else begin
                     st      <= ST_DELAY;
                     dly_cnt <= dly_qbits;
                  end
               end
            end
            ST_DELAY: begin
               if (!burst_en) st <= ST_IDLE;
               else if (qbit_stb) begin
                  dly_cnt <= dly_cnt - 1'b1;
                  if (dly_cnt == {{(DLY_W-1){1'b0}}, 1'b1}) begin
                     st   <= ST_UP;
                     addr <= '0;
                  end
               end
            end
            ST_UP: begin
               if (!burst_en) begin
                  st    <= ST_DOWN;
                  addr  <= ADDR_LAST;
                  phase <= 1'b0;
               end else if (step_en) begin
                  if (addr == ADDR_PEAK) st <= ST_HOLD;
                  else addr <= addr + 1'b1;
               end
            end
            ST_HOLD: begin
               if (!burst_en) begin
                  st    <= ST_DOWN;
                  addr  <= ADDR_LAST;
                  phase <= 1'b0;
               end
            end
            ST_DOWN: begin
               if (step_en) begin
                  if (addr == ADDR_LOW) begin
                     st   <= ST_IDLE;
                     addr <= '0;
                  end else addr <= addr - 1'b1;
               end
            end
            default: st <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/pa_ramp_calc.sv
module pa_ramp_calc #(
   parameter int SHAPE_W = 5,
   parameter int LEVEL_W = 8,
   parameter int OFFS_W  = 8,
   parameter int OUT_W   = 16,
   parameter bit REG_OUT = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               active,
   input  logic               pwr_down,
   input  logic               offs_mode,
   input  logic [SHAPE_W-1:0] shape,
   input  logic [LEVEL_W-1:0] level,
   input  logic [OFFS_W-1:0]  offset,
   output logic [OUT_W-1:0]   code
);
   logic [OUT_W-1:0] sh_x, lv_x, of_x, nxt;

   assign sh_x = OUT_W'(shape);
   assign lv_x = OUT_W'(level);
   assign of_x = OUT_W'(offset);

   always_comb begin
      if (!active || pwr_down || (level == '0)) nxt = '0;
      else if (offs_mode)                       nxt = sh_x * lv_x + of_x;
      else                                      nxt = sh_x * (lv_x + of_x);
   end

   if (REG_OUT) begin : g_reg
      logic [OUT_W-1:0] code_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) code_q <= '0;
         else        code_q <= nxt;
      end
      assign code = code_q;
   end else begin : g_comb
      assign code = nxt;
   end
endmodule

// File: rtl/pa_ramp_seq.sv
module pa_ramp_seq
   import pa_ramp_pkg::*;
#(
   parameter int ADDR_W  = 6,
   parameter int SHAPE_W = 5,
   parameter int LEVEL_W = 8,
   parameter int OFFS_W  = 8,
   parameter int DLY_W   = 4,
   parameter int OUT_W   = 16
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    tick_4m,
   input  logic                    qbit_stb,
   input  logic                    burst_en,
   input  logic                    pwr_down,
   input  logic                    slow_rate,
   input  logic                    offs_mode,
   input  logic [LEVEL_W-1:0]      level,
   input  logic [OFFS_W-1:0]       offset,
   input  logic [DLY_W-1:0]        dly_qbits,
   input  logic                    tbl_we,
   input  logic [ADDR_W-1:0]       tbl_waddr,
   input  logic [2*SHAPE_W-1:0]    tbl_wdata,
   output logic [OUT_W-1:0]        ctrl_out
);
   localparam int WORD_W = 2 * SHAPE_W;

   if (OUT_W < SHAPE_W + LEVEL_W + 1) begin : g_bad_out
      $error("OUT_W too narrow for the widest product");
   end
   if (OFFS_W > LEVEL_W) begin : g_bad_offs
      $error("OFFS_W must not exceed LEVEL_W");
   end
   if (ADDR_W < 2) begin : g_bad_addr
      $error("ADDR_W must be at least 2");
   end

   ramp_state_e        st;
   logic [ADDR_W-1:0]  addr;
   logic               step_en;
   logic               burst_rise;
   logic [WORD_W-1:0]  word;
   logic [SHAPE_W-1:0] shape;
   logic               active;

   pa_ramp_table #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_table (
      .clk   (clk),
      .we    (tbl_we),
      .waddr (tbl_waddr),
      .wdata (tbl_wdata),
      .raddr (addr),
      .rdata (word)
   );

   pa_ramp_fsm #(.ADDR_W(ADDR_W), .DLY_W(DLY_W)) u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick_4m    (tick_4m),
      .qbit_stb   (qbit_stb),
      .burst_en   (burst_en),
      .slow_rate  (slow_rate),
      .dly_qbits  (dly_qbits),
      .st         (st),
      .addr       (addr),
      .step_en    (step_en),
      .burst_rise (burst_rise)
   );

   assign active = (st == ST_UP) || (st == ST_HOLD) || (st == ST_DOWN);
   assign shape  = (st == ST_DOWN) ? word[WORD_W-1:SHAPE_W] : word[SHAPE_W-1:0];

   pa_ramp_calc #(
      .SHAPE_W (SHAPE_W),
      .LEVEL_W (LEVEL_W),
      .OFFS_W  (OFFS_W),
      .OUT_W   (OUT_W),
      .REG_OUT (1'b1)
   ) u_calc (
      .clk       (clk),
      .rst_n     (rst_n),
      .active    (active),
      .pwr_down  (pwr_down),
      .offs_mode (offs_mode),
      .shape     (shape),
      .level     (level),
      .offset    (offset),
      .code      (ctrl_out)
   );
endmodule

// File: rtl/pa_ramp_chk.sv
module pa_ramp_chk
   import pa_ramp_pkg::*;
#(
   parameter int ADDR_W  = 6,
   parameter int LEVEL_W = 8,
   parameter int DLY_W   = 4,
   parameter int OUT_W   = 16
) (
   input logic               clk,
   input logic               rst_n,
   input logic               burst_en,
   input logic               pwr_down,
   input logic [LEVEL_W-1:0] level,
   input logic [DLY_W-1:0]   dly_qbits,
   input logic [OUT_W-1:0]   ctrl_out,
   input ramp_state_e        st,
   input logic [ADDR_W-1:0]  addr,
   input logic               step_en,
   input logic               burst_rise
);
   localparam logic [ADDR_W-1:0] A_LAST = {ADDR_W{1'b1}};
   localparam logic [ADDR_W-1:0] A_PEAK = A_LAST - 1'b1;
   localparam logic [ADDR_W-1:0] A_LOW  = {{(ADDR_W-1){1'b0}}, 1'b1};

   a_r2_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_IDLE || st == ST_DELAY) |=> ctrl_out == '0);

   a_r10_pd_zero: assert property (@(posedge clk) disable iff (!rst_n)
      pwr_down |=> ctrl_out == '0);

   a_r10_level_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (level == '0) |=> ctrl_out == '0);

   a_r3_no_delay: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_IDLE && burst_rise && dly_qbits == '0) |=> (st == ST_UP && addr == '0));

   a_r4_up_step: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_UP && burst_en && step_en && addr != A_PEAK) |=> addr == $past(addr) + 1'b1);

   a_r6_hold_peak: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_HOLD) |-> addr == A_PEAK);

   a_r7_down_entry: assert property (@(posedge clk) disable iff (!rst_n)
      ((st == ST_UP || st == ST_HOLD) && !burst_en) |=> (st == ST_DOWN && addr == A_LAST));

   a_r7_down_exit: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_DOWN && step_en && addr == A_LOW) |=> st == ST_IDLE);

   a_r11_down_ignores_rise: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_DOWN && !step_en) |=> st == ST_DOWN);
endmodule

bind pa_ramp_seq pa_ramp_chk #(
   .ADDR_W  (ADDR_W),
   .LEVEL_W (LEVEL_W),
   .DLY_W   (DLY_W),
   .OUT_W   (OUT_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .burst_en   (burst_en),
   .pwr_down   (pwr_down),
   .level      (level),
   .dly_qbits  (dly_qbits),
   .ctrl_out   (ctrl_out),
   .st         (st),
   .addr       (addr),
   .step_en    (step_en),
   .burst_rise (burst_rise)
);

// File: tb/pa_ramp_seq_tb.sv
module pa_ramp_seq_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick_4m = 1'b0, qbit_stb = 1'b0, burst_en = 1'b0;
   logic        pwr_down = 1'b0, slow_rate = 1'b0, offs_mode = 1'b0;
   logic [7:0]  level = '0, offset = '0;
   logic [3:0]  dly_qbits = '0;
   logic        tbl_we = 1'b0;
   logic [5:0]  tbl_waddr = '0;
   logic [9:0]  tbl_wdata = '0;
   logic [15:0] ctrl_out;

   int checks = 0;
   int errors = 0;

   always #2.5 clk = ~clk;

   pa_ramp_seq dut_i (
      .clk(clk), .rst_n(rst_n), .tick_4m(tick_4m), .qbit_stb(qbit_stb),
      .burst_en(burst_en), .pwr_down(pwr_down), .slow_rate(slow_rate),
      .offs_mode(offs_mode), .level(level), .offset(offset),
      .dly_qbits(dly_qbits), .tbl_we(tbl_we), .tbl_waddr(tbl_waddr),
      .tbl_wdata(tbl_wdata), .ctrl_out(ctrl_out)
   );

   // shape fields written into the table (R1: up in [4:0], down in [9:5])
   function automatic logic [4:0] up_sh(int a);
      return 5'(a >> 1);
   endfunction
   function automatic logic [4:0] dn_sh(int a);
      return 5'((a * 3 + 7) % 32);
   endfunction

   // {offs_mode, level, offset, expected} with the hold sample up_sh(62) = 31
   localparam logic [32:0] VEC [6] = '{
      {1'b0, 8'd10,  8'd5,   16'd465},   // R8
      {1'b1, 8'd10,  8'd5,   16'd315},   // R9
      {1'b0, 8'd255, 8'd255, 16'd15810}, // R8 full scale
      {1'b1, 8'd255, 8'd255, 16'd8160},  // R9 full scale
      {1'b1, 8'd0,   8'd50,  16'd0},     // R10 level zero
      {1'b0, 8'd1,   8'd0,   16'd31}     // R8 unit level
   };

   task automatic chk(string tag, logic [15:0] exp);
      checks++;
      if (ctrl_out !== exp) begin
         errors++;
         $display("FAIL %s actual %0d expected %0d", tag, ctrl_out, exp);
      end
   endtask

   task automatic wait_n(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic ticks(int n);
      repeat (n) begin
         tick_4m = 1'b1; @(negedge clk);
         tick_4m = 1'b0; @(negedge clk);
      end
   endtask

   task automatic qstrobes(int n);
      repeat (n) begin
         qbit_stb = 1'b1; @(negedge clk);
         qbit_stb = 1'b0; @(negedge clk);
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      wait_n(3);
      chk("R2 reset", 16'd0);
      rst_n = 1'b1;
      wait_n(2);
      for (int a = 0; a < 64; a++) begin
         tbl_we = 1'b1; tbl_waddr = 6'(a); tbl_wdata = {dn_sh(a), up_sh(a)};
         @(negedge clk);
      end
      tbl_we = 1'b0;

      // R2: idle stays zero even in offset mode
      offs_mode = 1'b1; level = 8'd3; offset = 8'd50;
      wait_n(2);
      chk("R2 idle mode1", 16'd0);
      offs_mode = 1'b0; offset = 8'd0;

      // R3 delay of two quarter bits
      dly_qbits = 4'd2;
      burst_en = 1'b1;
      wait_n(2);
      chk("R3 in delay", 16'd0);
      qstrobes(1);
      ticks(2);
      chk("R3 one strobe owed", 16'd0);
      qstrobes(1);
      wait_n(1);
      ticks(2);
      chk("R4 addr2", 16'd3);
      ticks(38);
      chk("R4 addr40", 16'd60);
      ticks(22);
      chk("R4 addr62", 16'd93);
      ticks(4);
      chk("R6 hold", 16'd93);

      // vector walk in hold: R8 R9 R10 R12
      for (int i = 0; i < 6; i++) begin
         logic [15:0] prev;
         prev = (i == 0) ? 16'd93 : VEC[i-1][15:0];
         offs_mode = VEC[i][32]; level = VEC[i][31:24]; offset = VEC[i][23:16];
         #1;
         chk("R12 before edge", prev);
         @(negedge clk);
         chk("R8/R9/R10 vector", VEC[i][15:0]);
      end
      offs_mode = 1'b0; level = 8'd3; offset = 8'd0;
      wait_n(1);

      // R7 falling ramp, high field
      burst_en = 1'b0;
      wait_n(2);
      chk("R7 down addr63", 16'd12);
      ticks(1);
      chk("R7 down addr62", 16'd3);
      ticks(61);
      chk("R7 down addr1", 16'd30);
      ticks(1);
      chk("R7 back to idle", 16'd0);
      ticks(3);
      chk("R2 idle after ramp", 16'd0);

      // R5 slow rate, zero delay, abort
      slow_rate = 1'b1; dly_qbits = 4'd0;
      burst_en = 1'b1;
      wait_n(2);
      ticks(3);
      chk("R5 slow addr1", 16'd0);
      ticks(1);
      chk("R5 slow addr2", 16'd3);
      burst_en = 1'b0;
      wait_n(2);
      chk("R7 abort addr63", 16'd12);
      ticks(1);
      chk("R5 slow no step", 16'd12);
      ticks(1);
      chk("R5 slow addr62", 16'd3);
      burst_en = 1'b1; // R11 rise during falling ramp
      ticks(122);
      chk("R11 down continues addr1", 16'd30);
      ticks(2);
      chk("R11 idle after down", 16'd0);
      wait_n(6);
      chk("R11 no restart", 16'd0);
      burst_en = 1'b0;
      wait_n(2);

      // R10 power-down
      slow_rate = 1'b0; dly_qbits = 4'd1;
      burst_en = 1'b1;
      wait_n(2);
      qstrobes(1);
      wait_n(1);
      ticks(4);
      chk("R10 before pd addr4", 16'd6);
      pwr_down = 1'b1;
      wait_n(2);
      chk("R10 power-down", 16'd0);
      pwr_down = 1'b0;
      wait_n(2);
      chk("R10 pd released", 16'd6);

      // R3 fall during delay
      burst_en = 1'b0;
      wait_n(2);
      ticks(63);
      chk("R7 end of second ramp", 16'd0);
      dly_qbits = 4'd3;
      burst_en = 1'b1;
      wait_n(2);
      burst_en = 1'b0;
      wait_n(2);
      qstrobes(4);
      ticks(4);
      chk("R3 fall during delay", 16'd0);

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule